// File: doc/BRIEF.md
# Programmable Memory Attribute Checker

This block classifies a physical address against a bank of software-written attribute regions. Each region pairs an address register with an 8-bit configuration byte. The byte holds read, write and execute permissions, an address-match mode, a lock flag, and two memory attributes: atomics-allowed and cacheable. Addresses that fall in a non-cacheable region are sent down the uncached (MMIO) path.

A CSR-style write port updates the attribute registers. It takes effect only when the writer is in machine mode. A lookup port takes a word address (the address with its two byte-offset bits removed), an access kind and a flag that marks page-table-walker traffic. One clock later the block returns a fault flag, an MMIO flag and an atomics-allowed flag. Regions are checked in every privilege mode, and the lock flag has no effect on checking. After reset one catch-all region permits everything, so fetches can start at once.

Top module: `pma_attr_checker`

## Requirements
- R1: Configuration byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 match mode, bit 5 atomics allowed, bit 6 cacheable, bit 7 lock. Register select values 0 to 3 address the four configuration registers, and entry k sits in byte k mod 4 of register k div 4. Select values 16 to 31 address the address registers of entries 0 to 15, each holding write-data bits 29:0 as a word address.
- R2: A write changes any register only when csr_priv equals 3 (machine). Writes from any other privilege leave every register unchanged.
- R3: rsp_valid is high exactly one cycle after lk_valid. The result flags come from the lookup of that cycle and hold their value while no lookup is made.
- R4: Match modes: 0 disables the entry. 1 matches prev <= word < this, where prev is the address register of the entry below (0 for entry 0). 2 matches word == this. 3 matches an aligned power-of-two block whose size is 2^(t+1) words, where t is the number of trailing ones in the address register.
- R5: When several entries match, the lowest-numbered entry supplies the attributes.
- R6: An address that matches no entry reports fault and MMIO, and atomics are not allowed.
- R7: Access kind encoding is 0 read, 1 write, 2 execute, 3 atomic. A read needs R, a write needs W and an execute needs X. An atomic needs R, W and the atomics bit. A missing permission reports a fault.
- R8: rsp_mmio is high when the matching entry's cacheable bit is clear and low when it is set.
- R9: A page-table-walker lookup (lk_walker high) that resolves to MMIO reports a fault, even when the permissions allow it.
- R10: The lock bit changes neither the results nor later writes. Lookups carry no privilege, so every mode is checked the same way.
- R11: After reset, entry 15 is in mode 3 with an all-ones address and configuration byte 0x7F. It covers the whole space with every permission and is cacheable with atomics allowed. All other entries are zero.
- R12: rsp_atomic_ok reports the atomics bit of the matching entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized on release |
| csr_we | input | 1 | Register write strobe |
| csr_priv | input | 2 | Privilege of the writer (3 = machine) |
| csr_sel | input | 5 | Register select |
| csr_wdata | input | 32 | Write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr_word | input | 30 | Physical address bits 31:2 |
| lk_type | input | 2 | Access kind |
| lk_walker | input | 1 | Request comes from the page-table walker |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_fault | output | 1 | Access fault |
| rsp_mmio | output | 1 | Uncached (MMIO) routing |
| rsp_atomic_ok | output | 1 | Atomics permitted at this address |

## Verification
The assertions assume that register writes and lookups never fall in the same cycle, because a lookup then uses the values from before the write. They also assume that csr_sel and lk_type are stable while their strobes are high. The bench never overlaps the two strobes. It drives every input on the falling edge. It sweeps a band of word addresses with every access kind and both walker settings under five register images: reset, a mixed layout with overlaps, no catch-all, all entries locked, and writes refused from lower privileges. A bench-side arithmetic model predicts every flag.

// File: rtl/pma_pkg.sv
package pma_pkg;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_TOR   = 2'd1,
    MATCH_NA4   = 2'd2,
    MATCH_NAPOT = 2'd3
  } match_mode_e;

  typedef enum logic [1:0] {
    ACC_READ   = 2'd0,
    ACC_WRITE  = 2'd1,
    ACC_EXEC   = 2'd2,
    ACC_ATOMIC = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic        lock;
    logic        cache;
    logic        amo;
    match_mode_e mode;
    logic        x;
    logic        w;
    logic        r;
  } attr_cfg_t;

  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  localparam attr_cfg_t CFG_CATCH_ALL = '{lock: 1'b0, cache: 1'b1, amo: 1'b1,
                                          mode: MATCH_NAPOT, x: 1'b1, w: 1'b1,
                                          r: 1'b1};

endpackage

// File: rtl/pma_regfile.sv
module pma_regfile
  import pma_pkg::*;
#(
  parameter int N_ENTRY   = 16,
  parameter int XLEN      = 32,
  parameter int AW        = 30,
  parameter int ADDR_BASE = 16,
  parameter int SEL_W     = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          csr_we,
  input  logic [1:0]                    csr_priv,
  input  logic [SEL_W-1:0]              csr_sel,
  input  logic [XLEN-1:0]               csr_wdata,
  output attr_cfg_t [N_ENTRY-1:0]       cfg_q,
  output logic [N_ENTRY-1:0][AW-1:0]    addr_q
);

  localparam int PER_REG = XLEN / 8;

  attr_cfg_t [N_ENTRY-1:0]    cfg_d;
  logic [N_ENTRY-1:0][AW-1:0] addr_d;
  logic                       wr_en;

  assign wr_en = csr_we && (csr_priv == PRIV_MACHINE);

  always_comb begin
    cfg_d  = cfg_q;
    addr_d = addr_q;
    for (int i = 0; i < N_ENTRY; i++) begin
      if (csr_sel == SEL_W'(ADDR_BASE + i)) begin
        addr_d[i] = csr_wdata[AW-1:0];
      end
      if (csr_sel == SEL_W'(i / PER_REG)) begin
        cfg_d[i] = attr_cfg_t'(csr_wdata[(i % PER_REG)*8 +: 8]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENTRY; i++) begin
        cfg_q[i]  <= (i == N_ENTRY - 1) ? CFG_CATCH_ALL : attr_cfg_t'('0);
        addr_q[i] <= (i == N_ENTRY - 1) ? {AW{1'b1}} : {AW{1'b0}};
      end
    end else if (wr_en) begin
      cfg_q  <= cfg_d;
      addr_q <= addr_d;
    end
  end

  assert_low_priv_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_priv != PRIV_MACHINE) |=> ($stable(cfg_q) && $stable(addr_q)));

endmodule

// File: rtl/pma_entry_match.sv
module pma_entry_match
  import pma_pkg::*;
#(
  parameter int AW = 30
) (
  input  logic [AW-1:0] word,
  input  match_mode_e   mode,
  input  logic [AW-1:0] this_addr,
  input  logic [AW-1:0] prev_addr,
  output logic          hit
);

  logic [AW-1:0] span;
  logic          tor_hit;
  logic          na4_hit;
  logic          pow2_hit;

  assign span     = this_addr ^ (this_addr + AW'(1));
  assign tor_hit  = (word >= prev_addr) && (word < this_addr);
  assign na4_hit  = (word == this_addr);
  assign pow2_hit = (((word ^ this_addr) & ~span) == '0);

  always_comb begin
    unique case (mode)
      MATCH_TOR:   hit = tor_hit;
      MATCH_NA4:   hit = na4_hit;
      MATCH_NAPOT: hit = pow2_hit;
      default:     hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pma_first_hit.sv
module pma_first_hit #(
  parameter int N_ENTRY = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_ENTRY-1:0] req,
  output logic [N_ENTRY-1:0] grant,
  output logic [IDX_W-1:0]   idx,
  output logic               any
);

  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N_ENTRY - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
      end
    end
  end

  assign any = |req;

  assert_grant_is_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((grant & req) != '0));

  assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (((grant - N_ENTRY'(1)) & req) == '0));

endmodule

// File: rtl/pma_attr_checker.sv
module pma_attr_checker
  import pma_pkg::*;
#(
  parameter int N_ENTRY   = 16,
  parameter int XLEN      = 32,
  parameter int PA_W      = 32,
  parameter int ADDR_BASE = 16,
  parameter int SEL_W     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_we,
  input  logic [1:0]         csr_priv,
  input  logic [SEL_W-1:0]   csr_sel,
  input  logic [XLEN-1:0]    csr_wdata,
  input  logic               lk_valid,
  input  logic [PA_W-3:0]    lk_addr_word,
  input  logic [1:0]         lk_type,
  input  logic               lk_walker,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic               rsp_mmio,
  output logic               rsp_atomic_ok
);

  localparam int AW    = PA_W - 2;
  localparam int IDX_W = $clog2(N_ENTRY);

  attr_cfg_t [N_ENTRY-1:0]    cfg_q;
  logic [N_ENTRY-1:0][AW-1:0] addr_q;
  logic [N_ENTRY-1:0]         hit_vec;
  logic [N_ENTRY-1:0]         grant;
  logic [IDX_W-1:0]           hit_idx;
  logic                       any_hit;

  pma_regfile #(
    .N_ENTRY(N_ENTRY), .XLEN(XLEN), .AW(AW), .ADDR_BASE(ADDR_BASE), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_priv(csr_priv),
    .csr_sel(csr_sel), .csr_wdata(csr_wdata), .cfg_q(cfg_q), .addr_q(addr_q)
  );

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_entry
    logic [AW-1:0] lower;
    if (g == 0) begin : g_base
      assign lower = '0;
    end else begin : g_chain
      assign lower = addr_q[g-1];
    end
    pma_entry_match #(.AW(AW)) u_match (
      .word(lk_addr_word), .mode(cfg_q[g].mode), .this_addr(addr_q[g]),
      .prev_addr(lower), .hit(hit_vec[g])
    );
  end

  pma_first_hit #(.N_ENTRY(N_ENTRY), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(hit_vec), .grant(grant), .idx(hit_idx),
    .any(any_hit)
  );

  attr_cfg_t sel_cfg;
  logic      perm_ok;
  logic      mmio_d;
  logic      fault_d;
  logic      amo_d;

  assign sel_cfg = cfg_q[hit_idx];

  always_comb begin
    unique case (acc_kind_e'(lk_type))
      ACC_READ:   perm_ok = sel_cfg.r;
      ACC_WRITE:  perm_ok = sel_cfg.w;
      ACC_EXEC:   perm_ok = sel_cfg.x;
      default:    perm_ok = sel_cfg.r && sel_cfg.w && sel_cfg.amo;
    endcase
  end

  assign mmio_d  = !any_hit || !sel_cfg.cache;
  assign fault_d = !any_hit || !perm_ok || (lk_walker && mmio_d);
  assign amo_d   = any_hit && sel_cfg.amo;

  logic rsp_en;
  assign rsp_en = lk_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_fault     <= 1'b0;
      rsp_mmio      <= 1'b0;
      rsp_atomic_ok <= 1'b0;
    end else if (rsp_en) begin
      rsp_fault     <= fault_d;
      rsp_mmio      <= mmio_d;
      rsp_atomic_ok <= amo_d;
    end
  end

  assert_one_cycle_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && $stable(rsp_fault) && $stable(rsp_mmio)
                   && $stable(rsp_atomic_ok)));

  assert_miss_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !hit_vec[0] && !any_hit) |=> (rsp_fault && rsp_mmio && !rsp_atomic_ok));

  assert_walker_mmio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_walker && (grant != '0) && !sel_cfg.cache) |=> rsp_fault);

  assert_locked_still_checked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && any_hit && sel_cfg.lock && acc_kind_e'(lk_type) == ACC_READ && !sel_cfg.r)
    |=> rsp_fault);

endmodule

// File: tb/sim_pma_attr_checker.sv
module sim_pma_attr_checker;

  logic        clk;
  logic        rst_n;
  logic        csr_we;
  logic [1:0]  csr_priv;
  logic [4:0]  csr_sel;
  logic [31:0] csr_wdata;
  logic        lk_valid;
  logic [29:0] lk_addr_word;
  logic [1:0]  lk_type;
  logic        lk_walker;
  logic        rsp_valid;
  logic        rsp_fault;
  logic        rsp_mmio;
  logic        rsp_atomic_ok;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0]  m_cfg  [16];
  logic [29:0] m_addr [16];

  pma_attr_checker u0 (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_priv(csr_priv),
    .csr_sel(csr_sel), .csr_wdata(csr_wdata), .lk_valid(lk_valid),
    .lk_addr_word(lk_addr_word), .lk_type(lk_type), .lk_walker(lk_walker),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_mmio(rsp_mmio),
    .rsp_atomic_ok(rsp_atomic_ok)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // R1 register map: sel 0..3 config bytes, sel 16+k address of entry k
  task automatic csr_write(input logic [1:0] priv, input int sel, input logic [31:0] data);
    @(negedge clk);
    csr_we = 1'b1; csr_priv = priv; csr_sel = 5'(sel); csr_wdata = data;
    @(negedge clk);
    csr_we = 1'b0;
    if (priv == 2'b11) begin
      if (sel < 4) begin
        for (int b = 0; b < 4; b++) m_cfg[sel*4+b] = data[b*8 +: 8];
      end else if (sel >= 16) begin
        m_addr[sel-16] = data[29:0];
      end
    end
  endtask

  function automatic int model_hit(input logic [29:0] w);
    for (int i = 0; i < 16; i++) begin
      longint aw = longint'(m_addr[i]);
      longint lo = (i == 0) ? 0 : longint'(m_addr[i-1]);
      longint a  = longint'(w);
      bit ok = 0;
      case (m_cfg[i][4:3])
        2'd1: ok = (a >= lo) && (a < aw);
        2'd2: ok = (a == aw);
        2'd3: begin
          int t = 0;
          while (t < 30 && m_addr[i][t]) t++;
          if (t >= 29) ok = 1;
          else begin
            longint base = aw - ((64'd1 << t) - 1);
            ok = (a >= base) && (a < base + (64'd1 << (t + 1)));
          end
        end
        default: ok = 0;
      endcase
      if (ok) return i;
    end
    return -1;
  endfunction

  task automatic lookup_check(input logic [29:0] w, input logic [1:0] ty,
                              input logic walk, input string scen);
    int h;
    logic ef, em, ea, perm;
    logic [7:0] c;
    h = model_hit(w);
    if (h < 0) begin
      ef = 1; em = 1; ea = 0;
    end else begin
      c = m_cfg[h];
      case (ty)
        2'd0: perm = c[0];
        2'd1: perm = c[1];
        2'd2: perm = c[2];
        default: perm = c[0] & c[1] & c[5];
      endcase
      em = ~c[6];
      ea = c[5];
      ef = ~perm | (walk & em);
    end
    @(negedge clk);
    lk_valid = 1'b1; lk_addr_word = w; lk_type = ty; lk_walker = walk;
    @(negedge clk);
    check($sformatf("R3 valid %s w=%0d", scen, w), rsp_valid, 1'b1);
    if (h < 0) begin
      check($sformatf("R6 fault %s w=%0d t=%0d", scen, w, ty), rsp_fault, ef);
      check($sformatf("R6 mmio %s w=%0d", scen, w), rsp_mmio, em);
    end else begin
      if (walk && em)
        check($sformatf("R9 fault %s w=%0d t=%0d", scen, w, ty), rsp_fault, ef);
      else
        check($sformatf("R4 R5 R7 fault %s w=%0d t=%0d", scen, w, ty), rsp_fault, ef);
      check($sformatf("R8 mmio %s w=%0d", scen, w), rsp_mmio, em);
    end
    check($sformatf("R12 atomic %s w=%0d", scen, w), rsp_atomic_ok, ea);
    lk_valid = 1'b0;
  endtask

  task automatic sweep(input string scen);
    for (int w = 0; w < 128; w++)
      for (int ty = 0; ty < 4; ty++)
        for (int wk = 0; wk < 2; wk++)
          lookup_check(30'(w), 2'(ty), 1'(wk), scen);
    lookup_check(30'h3FFFFFFF, 2'd0, 1'b0, scen);
    lookup_check(30'h20000000, 2'd3, 1'b1, scen);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; csr_we = 0; csr_priv = 0; csr_sel = 0; csr_wdata = 0;
    lk_valid = 0; lk_addr_word = 0; lk_type = 0; lk_walker = 0;
    for (int i = 0; i < 16; i++) begin
      m_cfg[i]  = (i == 15) ? 8'h7F : 8'h00;
      m_addr[i] = (i == 15) ? 30'h3FFFFFFF : 30'h0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset rsp_valid", rsp_valid, 1'b0);
    check("R11 reset rsp_fault", rsp_fault, 1'b0);

    sweep("R11 reset image");

    // R3: flags hold while idle
    lookup_check(30'd5, 2'd3, 1'b0, "R3 prime");
    repeat (3) @(negedge clk);
    check("R3 idle valid", rsp_valid, 1'b0);
    check("R3 idle fault held", rsp_fault, 1'b0);
    check("R3 idle atomic held", rsp_atomic_ok, 1'b1);

    // Mixed layout with overlaps (R1 byte layout per entry)
    csr_write(2'b11, 16, 32'd16);
    csr_write(2'b11, 17, 32'd20);
    csr_write(2'b11, 18, 32'd39);
    csr_write(2'b11, 19, 32'd60);
    csr_write(2'b11, 20, 32'd7);
    csr_write(2'b11, 21, 32'd100);
    csr_write(2'b11, 22, 32'd70);
    csr_write(2'b11, 0, 32'h0C5F7309);
    csr_write(2'b11, 1, 32'h0033677F);
    sweep("R4 R5 mixed");

    // R5 explicit: word 3 hits entry 0 (read only) before entry 4 (all)
    lookup_check(30'd3, 2'd1, 1'b0, "R5 overlap");

    // R2: lower privileges cannot change anything
    for (int p = 0; p < 3; p++) begin
      csr_write(2'(p), 0, 32'h00000000);
      csr_write(2'(p), 18, 32'd0);
      csr_write(2'(p), 3, 32'h00000000);
    end
    sweep("R2 refused writes");

    // R10: lock bits set everywhere, results unchanged
    csr_write(2'b11, 0, 32'h0C5F7309 | 32'h80808080);
    csr_write(2'b11, 1, 32'h0033677F | 32'h80808080);
    csr_write(2'b11, 2, 32'h80808080);
    csr_write(2'b11, 3, 32'hFF808080);
    sweep("R10 locked");
    // R10: lock does not block later writes
    csr_write(2'b11, 22, 32'd71);
    lookup_check(30'd71, 2'd0, 1'b1, "R10 write after lock");

    // R6: no catch-all
    csr_write(2'b11, 3, 32'h00000000);
    sweep("R6 no default");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule